// File: doc/BRIEF.md
# Word/Byte Host Bus Front-End with Address-Stable Sleep

This block sits between the external parallel pins of a flash-style memory and its internal logic. Every clock it samples the chip-enable, output-enable, write-enable, hardware-reset and width-select pins. It then decodes them into one bus operation: reset, standby, output-disable, read or write. It forms a byte-granular internal address and drives the two tristate enables for the low and high data lanes. In 8-bit mode the top data pin serves as the least significant address bit rather than as data.

Read data comes from the array. It passes through a holding register that feeds the data pins. A timer watches the formed address. When the address has stayed unchanged for a set number of cycles, the timer enters a sleep state. The holding register then freezes, and the pins keep showing the last value whatever the array presents. Any address change wakes the block at once. Writes are framed by chip-enable and write-enable together. The address and data are taken while both are low, and they are released as a one-cycle strobe once both have returned high.

Top module: `flash_bus_frontend`

## Requirements
- R1: Pins are sampled on each rising clock. One cycle later `bus_op` shows the decoded operation: 0 when reset pin low; else 1 when chip-enable high (standby); else 4 when write-enable low and output-enable high (write); else 3 when output-enable low and write-enable high (read); else 2 (output disabled, including both enables low).
- R2: In 16-bit mode (width-select high), `mem_addr` is `{addr, 1'b0}` and a read enables both data lanes with the full array word on `dq_out`.
- R3: In 8-bit mode (width-select low), `mem_addr` is `{addr, dq_in[15]}`. Only the low lane is enabled. `dq_out[7:0]` carries array bits 15:8 when that lowest bit is 1 and bits 7:0 when it is 0, and `dq_out[15:8]` is zero.
- R4: With output-enable high, neither lane is enabled.
- R5: With the reset pin low, neither lane is enabled, no write strobe is issued, and a write in progress is abandoned without a strobe.
- R6: With chip-enable high, neither lane is enabled, whatever output-enable does.
- R7: After the formed address has been unchanged for `SLEEP_CYC` cycles, `sleep` rises whatever the control pins do (SLEEP_CYC+2 edges after the pin change), and `dq_out` then stays fixed even if the array data changes.
- R8: Any change of the formed address, including the lowest bit in 8-bit mode, drops `sleep` one cycle after the change and restarts the count.
- R9: A write opens when chip-enable and write-enable are both low with output-enable high. The address and data are taken on every cycle both stay low, and are held while only one of them is high. `wr_strobe` pulses for one cycle after both are high again, that is, on the later of the two rising edges. In 8-bit mode `wr_data` is `{8'h00, dq_in[7:0]}`.
- R10: After synchronous reset, `bus_op` is 0, both lane enables are low, `sleep` is low and `wr_strobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| reset_n | input | 1 | Hardware reset pin, active low |
| byte_n | input | 1 | Width select: high 16-bit, low 8-bit |
| addr | input | ADDR_W | Word address pins |
| dq_in | input | 16 | Input side of the data pins |
| rd_data | input | 16 | Array word at `mem_addr` |
| dq_out | output | 16 | Output side of the data pins |
| dq_oe_lo | output | 1 | Drive enable for data bits 7:0 |
| dq_oe_hi | output | 1 | Drive enable for data bits 15:8 |
| bus_op | output | 3 | Decoded operation code |
| mem_addr | output | ADDR_W+1 | Byte-granular internal address |
| sleep | output | 1 | Address-stable sleep state |
| wr_strobe | output | 1 | One-cycle write release |
| wr_addr | output | ADDR_W+1 | Captured write address |
| wr_data | output | 16 | Captured write data |

## Verification
The properties assume that every pin is driven to a defined level from the first clock after reset. They also assume that the array returns `rd_data` combinationally for the current `mem_addr`, so that a held output is an effect of sleep and not of the array. The bench changes pins only at falling clock edges and keeps each level for several cycles. After every write it raises both strobes before any reset or mode change, so no pin changes race the sampling edge.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    localparam int FE_DATA_W = 16;
    localparam int FE_LANE_W = FE_DATA_W / 2;

    typedef enum logic [2:0] {
        BUS_RESET   = 3'd0,
        BUS_STANDBY = 3'd1,
        BUS_OUTOFF  = 3'd2,
        BUS_READ    = 3'd3,
        BUS_WRITE   = 3'd4
    } bus_op_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic rst_n;
        logic byte_n;
        logic d15;
    } pins_t;

    function automatic bus_op_e decode_op(input pins_t p);
        if (!p.rst_n)                 return BUS_RESET;
        else if (p.ce_n)              return BUS_STANDBY;
        else if (!p.we_n && p.oe_n)   return BUS_WRITE;
        else if (!p.oe_n && p.we_n)   return BUS_READ;
        else                          return BUS_OUTOFF;
    endfunction

    function automatic logic [FE_DATA_W-1:0] lane_pick(
        input logic                 byte_n,
        input logic                 lsb,
        input logic [FE_DATA_W-1:0] word
    );
        if (byte_n) return word;
        return {{FE_LANE_W{1'b0}},
                (lsb ? word[FE_DATA_W-1:FE_LANE_W] : word[FE_LANE_W-1:0])};
    endfunction

endpackage

// File: rtl/fe_pin_sampler.sv
module fe_pin_sampler
    import flash_fe_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce_n,
    input  logic                 oe_n,
    input  logic                 we_n,
    input  logic                 reset_n,
    input  logic                 byte_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [FE_DATA_W-1:0] dq_in,
    output pins_t                s_pins,
    output logic [ADDR_W-1:0]    s_addr,
    output logic [FE_DATA_W-1:0] s_dq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            s_pins <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                        rst_n: 1'b0, byte_n: 1'b1, d15: 1'b0};
            s_addr <= '0;
            s_dq   <= '0;
        end else begin
            s_pins <= '{ce_n: ce_n, oe_n: oe_n, we_n: we_n,
                        rst_n: reset_n, byte_n: byte_n,
                        d15: dq_in[FE_DATA_W-1]};
            s_addr <= addr;
            s_dq   <= dq_in;
        end
    end
endmodule

// File: rtl/fe_sleep_timer.sv
module fe_sleep_timer #(
    parameter int AW        = 22,
    parameter int SLEEP_CYC = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cur_addr,
    output logic          sleep
);
    localparam int CNT_W = $clog2(SLEEP_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SLEEP_CYC);

    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    last_addr;
    logic             same;

    assign same  = (cur_addr == last_addr);
    assign sleep = same && (cnt == LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            last_addr <= '0;
        end else begin
            last_addr <= cur_addr;
            if (!same)
                cnt <= '0;
            else if (cnt != LIMIT)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fe_write_capture.sv
module fe_write_capture
    import flash_fe_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pins_t                s_pins,
    input  logic [AW-1:0]        cur_addr,
    input  logic [FE_DATA_W-1:0] s_dq,
    output logic                 wr_strobe,
    output logic [AW-1:0]        wr_addr,
    output logic [FE_DATA_W-1:0] wr_data
);
    logic busy;
    logic both_low;
    logic both_high;
    logic opening;

    assign both_low  = !s_pins.ce_n && !s_pins.we_n;
    assign both_high = s_pins.ce_n && s_pins.we_n;
    assign opening   = s_pins.rst_n && both_low && s_pins.oe_n;
    assign wr_strobe = busy && both_high && s_pins.rst_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else if (!s_pins.rst_n) begin
            busy <= 1'b0;
        end else begin
            if (opening)
                busy <= 1'b1;
            else if (busy && both_high)
                busy <= 1'b0;
            if ((opening || busy) && both_low) begin
                wr_addr <= cur_addr;
                wr_data <= s_pins.byte_n ? s_dq
                         : {{FE_LANE_W{1'b0}}, s_dq[FE_LANE_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/fe_read_path.sv
module fe_read_path
    import flash_fe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sleep,
    input  logic                 byte_n,
    input  logic                 lsb,
    input  logic [FE_DATA_W-1:0] rd_data,
    output logic [FE_DATA_W-1:0] dq_out
);
    always_ff @(posedge clk) begin
        if (rst)
            dq_out <= '0;
        else if (!sleep)
            dq_out <= lane_pick(byte_n, lsb, rd_data);
    end
endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
    import flash_fe_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int SLEEP_CYC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce_n,
    input  logic                 oe_n,
    input  logic                 we_n,
    input  logic                 reset_n,
    input  logic                 byte_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [15:0]          dq_in,
    input  logic [15:0]          rd_data,
    output logic [15:0]          dq_out,
    output logic                 dq_oe_lo,
    output logic                 dq_oe_hi,
    output logic [2:0]           bus_op,
    output logic [ADDR_W:0]      mem_addr,
    output logic                 sleep,
    output logic                 wr_strobe,
    output logic [ADDR_W:0]      wr_addr,
    output logic [15:0]          wr_data
);
    localparam int AW = ADDR_W + 1;

    pins_t               s_pins;
    logic [ADDR_W-1:0]   s_addr;
    logic [FE_DATA_W-1:0] s_dq;
    bus_op_e             op;
    logic                addr_lsb;

    fe_pin_sampler #(.ADDR_W(ADDR_W)) u_smp (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .reset_n(reset_n), .byte_n(byte_n), .addr(addr), .dq_in(dq_in),
        .s_pins(s_pins), .s_addr(s_addr), .s_dq(s_dq)
    );

    assign op       = decode_op(s_pins);
    assign bus_op   = op;
    assign addr_lsb = s_pins.byte_n ? 1'b0 : s_pins.d15;
    assign mem_addr = {s_addr, addr_lsb};
    assign dq_oe_lo = (op == BUS_READ);
    assign dq_oe_hi = (op == BUS_READ) && s_pins.byte_n;

    fe_sleep_timer #(.AW(AW), .SLEEP_CYC(SLEEP_CYC)) u_slp (
        .clk(clk), .rst(rst), .cur_addr(mem_addr), .sleep(sleep)
    );

    fe_read_path u_rd (
        .clk(clk), .rst(rst), .sleep(sleep), .byte_n(s_pins.byte_n),
        .lsb(addr_lsb), .rd_data(rd_data), .dq_out(dq_out)
    );

    fe_write_capture #(.AW(AW)) u_wr (
        .clk(clk), .rst(rst), .s_pins(s_pins), .cur_addr(mem_addr),
        .s_dq(s_dq), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );
endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              reset_n,
    input logic              byte_n,
    input logic [15:0]       dq_out,
    input logic              dq_oe_lo,
    input logic              dq_oe_hi,
    input logic [2:0]        bus_op,
    input logic [ADDR_W:0]   mem_addr,
    input logic              sleep,
    input logic              wr_strobe
);
    AST_READ_DECODE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!ce_n && !oe_n && we_n && reset_n)) |-> (bus_op == 3'd3)); // R1
    AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (rst)
        dq_oe_hi |-> dq_oe_lo); // R2
    AST_BYTE_NO_HI: assert property (@(posedge clk) disable iff (rst)
        !$past(byte_n) |-> !dq_oe_hi); // R3
    AST_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(oe_n) |-> !dq_oe_lo); // R4
    AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$past(reset_n) |-> (!dq_oe_lo && !wr_strobe && bus_op == 3'd0)); // R5
    AST_CE_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(ce_n) |-> !dq_oe_lo); // R6
    AST_SLEEP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (sleep && $past(sleep)) |-> $stable(dq_out)); // R7
    AST_WAKE: assert property (@(posedge clk) disable iff (rst)
        (mem_addr != $past(mem_addr)) |-> !sleep); // R8
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> !wr_strobe); // R9
endmodule

bind flash_bus_frontend fe_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .reset_n(reset_n), .byte_n(byte_n), .dq_out(dq_out),
    .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi), .bus_op(bus_op),
    .mem_addr(mem_addr), .sleep(sleep), .wr_strobe(wr_strobe)
);

// File: tb/sim_flash_bus_frontend.sv
module sim_flash_bus_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 21;
    localparam int SLEEP_CYC  = 8;
    localparam int NVEC       = 9;

    // vector: ce oe we rst_n byte_n | addr[7:0] | d15 | op[2:0] | lo | hi
    localparam logic [18:0] VECS [0:NVEC-1] = '{
        {5'b00111, 8'h12, 1'b0, 3'd3, 1'b1, 1'b1},  // R2 word read
        {5'b00110, 8'h34, 1'b0, 3'd3, 1'b1, 1'b0},  // R3 byte read low half
        {5'b00110, 8'h34, 1'b1, 3'd3, 1'b1, 1'b0},  // R3 byte read high half
        {5'b01111, 8'h20, 1'b0, 3'd2, 1'b0, 1'b0},  // R4 output disabled
        {5'b10111, 8'h21, 1'b0, 3'd1, 1'b0, 1'b0},  // R6 standby with oe low
        {5'b00101, 8'h22, 1'b0, 3'd0, 1'b0, 1'b0},  // R5 reset pin low
        {5'b00111, 8'h56, 1'b1, 3'd3, 1'b1, 1'b1},  // R2 top pin ignored as address
        {5'b01011, 8'h23, 1'b0, 3'd4, 1'b0, 1'b0},  // R1 write decode
        {5'b00011, 8'h24, 1'b0, 3'd2, 1'b0, 1'b0}   // R1 both enables low
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, reset_n = 1'b1, byte_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] rd_data;
    logic corrupt = 1'b0;
    logic [15:0] dq_out, wr_data;
    logic dq_oe_lo, dq_oe_hi, sleep, wr_strobe;
    logic [2:0] bus_op;
    logic [ADDR_W:0] mem_addr, wr_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] model(input logic [ADDR_W-1:0] w);
        return {w[7:0] ^ 8'hA5, w[7:0] ^ 8'h3C};
    endfunction

    assign rd_data = corrupt ? 16'hDEAD : model(mem_addr[ADDR_W:1]);

    flash_bus_frontend #(.ADDR_W(ADDR_W), .SLEEP_CYC(SLEEP_CYC)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .reset_n(reset_n), .byte_n(byte_n), .addr(addr), .dq_in(dq_in),
        .rd_data(rd_data), .dq_out(dq_out), .dq_oe_lo(dq_oe_lo),
        .dq_oe_hi(dq_oe_hi), .bus_op(bus_op), .mem_addr(mem_addr),
        .sleep(sleep), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pins(input logic c, input logic o, input logic w,
                        input logic r, input logic b);
        ce_n = c; oe_n = o; we_n = w; reset_n = r; byte_n = b;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        // R10 reset state, seen before the first post-reset edge
        chk(bus_op == 3'd0, "R10 op", 32'(bus_op), 0);
        chk(!dq_oe_lo && !dq_oe_hi, "R10 lanes", {dq_oe_hi, dq_oe_lo}, 0);
        chk(!sleep, "R10 sleep", 32'(sleep), 0);
        chk(!wr_strobe, "R10 strobe", 32'(wr_strobe), 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [18:0] v;
            logic [ADDR_W:0] ea;
            logic [15:0] ew;
            v = VECS[i];
            pins(v[18], v[17], v[16], v[15], v[14]);
            addr = ADDR_W'(v[13:6]);
            dq_in = {v[5], 15'h0};
            cyc(3);
            ea = v[14] ? {addr, 1'b0} : {addr, v[5]};
            ew = model(addr);
            chk(bus_op == v[4:2], "R1 op decode", 32'(bus_op), 32'(v[4:2]));
            chk({dq_oe_lo, dq_oe_hi} == v[1:0], "R4/R5/R6 lane enables",
                {dq_oe_lo, dq_oe_hi}, 32'(v[1:0]));
            chk(mem_addr == ea, v[14] ? "R2 address" : "R3 address",
                32'(mem_addr), 32'(ea));
            if (v[1]) begin
                if (v[14])
                    chk(dq_out == ew, "R2 read data", dq_out, ew);
                else
                    chk(dq_out == {8'h00, v[5] ? ew[15:8] : ew[7:0]},
                        "R3 byte lane data", dq_out,
                        {8'h00, v[5] ? ew[15:8] : ew[7:0]});
            end
        end

        // R9 word write: we rises first, ce later; data changes after we rises
        pins(1, 1, 1, 1, 1); cyc(3);
        addr = 21'h1AB; dq_in = 16'hBEEF;
        pins(0, 1, 0, 1, 1); cyc(3);
        we_n = 1'b1; dq_in = 16'h1234; cyc(1);
        chk(!wr_strobe, "R9 no strobe while ce low", 32'(wr_strobe), 0);
        ce_n = 1'b1; cyc(1);
        chk(wr_strobe, "R9 strobe on later rise", 32'(wr_strobe), 1);
        chk(wr_addr == {21'h1AB, 1'b0}, "R9 word address", 32'(wr_addr), 32'h356);
        chk(wr_data == 16'hBEEF, "R9 word data", wr_data, 16'hBEEF);
        cyc(1);
        chk(!wr_strobe, "R9 single pulse", 32'(wr_strobe), 0);

        // R9 byte write, top pin acts as lowest address bit
        addr = 21'h002; dq_in = 16'h8077;
        pins(0, 1, 0, 1, 0); cyc(3);
        pins(1, 1, 1, 1, 0); cyc(1);
        chk(wr_strobe, "R9 byte strobe", 32'(wr_strobe), 1);
        chk(wr_addr == 22'h5, "R9 byte address", 32'(wr_addr), 5);
        chk(wr_data == 16'h0077, "R9 byte data", wr_data, 16'h0077);

        // R5 write abandoned by reset pin
        byte_n = 1'b1; cyc(2);
        addr = 21'h0F0; dq_in = 16'h5555;
        pins(0, 1, 0, 1, 1); cyc(3);
        reset_n = 1'b0; cyc(2);
        chk(!wr_strobe && bus_op == 3'd0, "R5 reset op", {wr_strobe, bus_op}, 0);
        pins(1, 1, 1, 0, 1); cyc(2);
        reset_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cyc(1);
            chk(!wr_strobe, "R5 no strobe after abort", 32'(wr_strobe), 0);
        end

        // R7 sleep in word read, then frozen output
        dq_in = 16'h0000;
        addr = 21'h040; pins(0, 0, 1, 1, 1);
        cyc(SLEEP_CYC + 1);
        chk(!sleep, "R7 not yet asleep", 32'(sleep), 0);
        chk(dq_out == model(21'h040), "R7 data before sleep", dq_out, model(21'h040));
        cyc(1);
        chk(sleep, "R7 asleep", 32'(sleep), 1);
        corrupt = 1'b1; cyc(3);
        chk(dq_out == model(21'h040), "R7 output held", dq_out, model(21'h040));
        chk(sleep, "R7 stays asleep", 32'(sleep), 1);
        corrupt = 1'b0;
        addr = 21'h041; cyc(1);
        chk(!sleep, "R8 wake on address", 32'(sleep), 0);
        cyc(2);
        chk(dq_out == model(21'h041), "R8 fresh data", dq_out, model(21'h041));

        // R7 sleep regardless of control pins (standby)
        pins(1, 1, 1, 1, 1); addr = 21'h077;
        cyc(SLEEP_CYC + 2);
        chk(sleep, "R7 sleep in standby", 32'(sleep), 1);

        // R8 byte mode: toggling the top pin alone wakes
        pins(0, 0, 1, 1, 0); addr = 21'h010; dq_in = 16'h0000;
        cyc(SLEEP_CYC + 2);
        chk(sleep, "R7 byte asleep", 32'(sleep), 1);
        dq_in = 16'h8000; cyc(1);
        chk(!sleep, "R8 wake on lowest bit", 32'(sleep), 0);
        cyc(2);
        chk(dq_out == {8'h00, model(21'h010)[15:8]}, "R3 high half after wake",
            dq_out, {8'h00, model(21'h010)[15:8]});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule